// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between a UART receiver's deserializer and its receive buffer on a multidrop serial bus. Each finished character arrives with a frame-done strobe, its data bits, its stop-bit samples and its parity and buffer-full conditions. The block decides whether the character is an address or a data frame, and produces a one-cycle write strobe into the receive buffer with the captured character and its error flags.

A listen-for-address mode bit governs what passes. While the bit is set, only address frames reach the buffer. Data frames are dropped without a trace, so they raise no error flag. Software inspects each address, clears the mode bit when its node is selected and sets it again after the last data frame. The mode bit shares a two-bit control word with a transmit-done flag that is cleared by writing a one. A write that only changes the mode bit therefore leaves that flag alone.

In 9-bit character mode the ninth data bit carries the frame type. In the narrower modes the first stop bit carries the type, and the second stop bit is the one checked for framing.

Top module: `mpf_filter`

## Requirements
- R1: In 9-bit mode (`nine_bit`=1), `rx_data[8]`=1 marks an address frame and 0 a data frame. `buf_addr` reports the type and `buf_data` carries all nine bits. The frame error is the inverse of `rx_stop1`.
- R2: While `mode_q`=1, a data frame produces no `buf_wr` pulse.
- R3: While `mode_q`=1, an address frame is written to the buffer with its data and flags.
- R4: While `mode_q`=0, every frame is written, whatever its type.
- R5: In narrow mode (`nine_bit`=0), `rx_stop1`=1 marks an address frame and 0 a data frame. The frame error is the inverse of `rx_stop2`, and `buf_data[8]` is zero.
- R6: `buf_wr` is high for exactly one clock, in the cycle after the clock edge that sampled `rx_done`. `buf_data`, `buf_addr`, `buf_fe`, `buf_pe` and `buf_ovr` then hold that frame's values, with `buf_ovr` taken from `rx_buf_full`. These outputs stay unchanged until the next accepted frame.
- R7: A discarded data frame does not change `buf_fe`, `buf_pe` or `buf_ovr`, however erroneous it was.
- R8: A write (`csr_wr`=1) loads `mode_q` from `csr_wdata[0]`. If `csr_wdata[1]`=0, `txc_q` keeps its value.
- R9: A `tx_done` pulse sets `txc_q`. A write with `csr_wdata[1]`=1 clears it. When both happen in the same cycle, the set wins.
- R10: After reset, `mode_q`=0, `txc_q`=0 and `buf_wr`=0.
- R11: A frame whose `rx_done` coincides with a write to the mode bit is filtered by the mode value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nine_bit | input | 1 | 1 = 9-bit characters, 0 = 5- to 8-bit characters |
| rx_data | input | 9 | Deserialized character bits |
| rx_stop1 | input | 1 | Sample of the first stop bit |
| rx_stop2 | input | 1 | Sample of the second stop bit |
| rx_par_err | input | 1 | Parity mismatch for this character |
| rx_buf_full | input | 1 | Receive buffer was full when this character finished |
| rx_done | input | 1 | Character complete strobe |
| csr_wr | input | 1 | Control word write enable |
| csr_wdata | input | 2 | Bit 0: mode value; bit 1: write one to clear `txc_q` |
| tx_done | input | 1 | Transmitter finished a frame with nothing pending |
| mode_q | output | 1 | Address-listen mode bit |
| txc_q | output | 1 | Transmit-done flag |
| buf_wr | output | 1 | Qualified write strobe into the receive buffer |
| buf_data | output | 9 | Character written to the buffer |
| buf_addr | output | 1 | Written character was an address frame |
| buf_fe | output | 1 | Framing error of the written character |
| buf_pe | output | 1 | Parity error of the written character |
| buf_ovr | output | 1 | Overrun condition of the written character |

## Verification
The hardest case to reach is a frame that finishes in the same cycle as a software write that flips the mode bit. The bench places `rx_done` and `csr_wr` on the same negative clock edge. It then checks that the frame was judged by the old mode value, while `mode_q` already shows the new one. A second difficult case is a discarded data frame that carries every error condition at once. The bench follows it with a clean address frame and reads the captured flags, to show that nothing from the dropped frame leaked through.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int unsigned DATA_W   = 9;
  localparam int unsigned CSR_W    = 2;
  localparam int unsigned MODE_POS = 0;
  localparam int unsigned TXC_POS  = 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              addr;
    logic              fe;
    logic              pe;
    logic              ovr;
  } rx_word_t;
endpackage

// File: rtl/mpf_rst_sync.sv
module mpf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mpf_csr.sv
module mpf_csr #(
  parameter int unsigned W        = mpf_pkg::CSR_W,
  parameter int unsigned MODE_POS = mpf_pkg::MODE_POS,
  parameter int unsigned TXC_POS  = mpf_pkg::TXC_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         tx_done,
  output logic         mode_q,
  output logic         txc_q
);
  logic mode_d;
  logic txc_d;

  // mode is a plain bit; txc is set by hardware, cleared by writing one
  always_comb begin
    mode_d = mode_q;
    txc_d  = txc_q;
    if (wr_en) begin
      mode_d = wdata[MODE_POS];
      if (wdata[TXC_POS]) txc_d = 1'b0;
    end
    if (tx_done) txc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      txc_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      txc_q  <= txc_d;
    end
  end
endmodule

// File: rtl/mpf_type_decode.sv
module mpf_type_decode #(
  parameter int unsigned W = mpf_pkg::DATA_W
) (
  input  logic         nine_bit,
  input  logic [W-1:0] data_in,
  input  logic         stop1,
  input  logic         stop2,
  output logic         is_addr,
  output logic         frame_err,
  output logic [W-1:0] data_out
);
  localparam int unsigned NARROW_W = W - 1;

  always_comb begin
    if (nine_bit) begin
      is_addr   = data_in[W-1];
      frame_err = ~stop1;
      data_out  = data_in;
    end else begin
      // first stop bit is the type marker, second one is checked
      is_addr   = stop1;
      frame_err = ~stop2;
      data_out  = {1'b0, data_in[NARROW_W-1:0]};
    end
  end
endmodule

// File: rtl/mpf_gate.sv
module mpf_gate
  import mpf_pkg::*;
#(
  parameter int unsigned W = mpf_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic         mode,
  input  logic         is_addr,
  input  logic         fe,
  input  logic         pe,
  input  logic         full,
  input  logic [W-1:0] data,
  output logic         wr_q,
  output rx_word_t     word_q
);
  logic     accept;
  logic     wr_d;
  rx_word_t word_d;

  always_comb begin
    accept = done & (~mode | is_addr);
    wr_d   = accept;
    word_d = '{data: data, addr: is_addr, fe: fe, pe: pe, ovr: full};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      word_q <= '0;
    end else begin
      wr_q <= wr_d;
      if (accept) word_q <= word_d;
    end
  end
endmodule

// File: rtl/mpf_filter.sv
module mpf_filter
  import mpf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nine_bit,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_stop1,
  input  logic              rx_stop2,
  input  logic              rx_par_err,
  input  logic              rx_buf_full,
  input  logic              rx_done,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  input  logic              tx_done,
  output logic              mode_q,
  output logic              txc_q,
  output logic              buf_wr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_addr,
  output logic              buf_fe,
  output logic              buf_pe,
  output logic              buf_ovr
);
  logic              rst_core_n;
  logic              is_addr;
  logic              frame_err;
  logic [DATA_W-1:0] data_norm;
  rx_word_t          word_q;

  mpf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  mpf_csr #(.W(CSR_W), .MODE_POS(MODE_POS), .TXC_POS(TXC_POS)) u_csr (
    .clk(clk), .rst_n(rst_core_n), .wr_en(csr_wr), .wdata(csr_wdata),
    .tx_done(tx_done), .mode_q(mode_q), .txc_q(txc_q)
  );

  mpf_type_decode #(.W(DATA_W)) u_dec (
    .nine_bit(nine_bit), .data_in(rx_data), .stop1(rx_stop1), .stop2(rx_stop2),
    .is_addr(is_addr), .frame_err(frame_err), .data_out(data_norm)
  );

  mpf_gate #(.W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_core_n), .done(rx_done), .mode(mode_q),
    .is_addr(is_addr), .fe(frame_err), .pe(rx_par_err), .full(rx_buf_full),
    .data(data_norm), .wr_q(buf_wr), .word_q(word_q)
  );

  assign buf_data = word_q.data;
  assign buf_addr = word_q.addr;
  assign buf_fe   = word_q.fe;
  assign buf_pe   = word_q.pe;
  assign buf_ovr  = word_q.ovr;
endmodule

// File: rtl/mpf_filter_chk.sv
module mpf_filter_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       nine_bit,
  input logic [8:0] rx_data,
  input logic       rx_stop1,
  input logic       rx_done,
  input logic       csr_wr,
  input logic [1:0] csr_wdata,
  input logic       tx_done,
  input logic       mode_q,
  input logic       txc_q,
  input logic       buf_wr,
  input logic [8:0] buf_data,
  input logic       buf_addr
);
  logic frame_is_addr;
  assign frame_is_addr = nine_bit ? rx_data[8] : rx_stop1;

  // R2
  drop_data_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_done && mode_q && !frame_is_addr) |=> !buf_wr);

  // R3
  pass_addr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_done && frame_is_addr) |=> (buf_wr && buf_addr));

  // R4
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_done && !mode_q) |=> buf_wr);

  // R6
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    buf_wr |-> $past(rx_done));

  // R5
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (buf_wr && $past(!nine_bit)) |-> !buf_data[8]);

  // R8
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    csr_wr |=> (mode_q == $past(csr_wdata[0])));

  // R9
  txc_set_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_done |=> txc_q);

  // R8
  txc_keep_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (csr_wr && !csr_wdata[1] && !tx_done) |=> $stable(txc_q));
endmodule

bind mpf_filter mpf_filter_chk u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .nine_bit(nine_bit), .rx_data(rx_data),
  .rx_stop1(rx_stop1), .rx_done(rx_done), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
  .tx_done(tx_done), .mode_q(mode_q), .txc_q(txc_q), .buf_wr(buf_wr),
  .buf_data(buf_data), .buf_addr(buf_addr)
);

// File: tb/sim_mpf_filter.sv
module sim_mpf_filter;
  logic       clk;
  logic       rst_n;
  logic       nine_bit;
  logic [8:0] rx_data;
  logic       rx_stop1, rx_stop2, rx_par_err, rx_buf_full, rx_done;
  logic       csr_wr;
  logic [1:0] csr_wdata;
  logic       tx_done;
  logic       mode_q, txc_q, buf_wr, buf_addr, buf_fe, buf_pe, buf_ovr;
  logic [8:0] buf_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  mpf_filter u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one frame for a cycle; sample the strobe cycle at the next negedge
  task automatic frame(input bit nb, input logic [8:0] d, input bit s1, input bit s2,
                       input bit pe, input bit full);
    @(negedge clk);
    nine_bit = nb; rx_data = d; rx_stop1 = s1; rx_stop2 = s2;
    rx_par_err = pe; rx_buf_full = full; rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0; rx_par_err = 1'b0; rx_buf_full = 1'b0;
  endtask

  task automatic csr_write(input logic [1:0] w);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = w;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(mode_q == 1'b0, "R10 mode", mode_q, 0);
    chk(txc_q == 1'b0, "R10 txc", txc_q, 0);
    chk(buf_wr == 1'b0, "R10 wr", buf_wr, 0);
  endtask

  task automatic t_nine_open;
    frame(1'b1, 9'h0A5, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(buf_wr == 1'b1, "R4 data frame passes", buf_wr, 1);
    chk(buf_data == 9'h0A5, "R1 data", buf_data, 9'h0A5);
    chk(buf_addr == 1'b0, "R1 type data", buf_addr, 0);
    chk(buf_fe == 1'b0, "R1 fe clear", buf_fe, 0);
    @(negedge clk);
    chk(buf_wr == 1'b0, "R6 one-cycle strobe", buf_wr, 0);
    chk(buf_data == 9'h0A5, "R6 hold", buf_data, 9'h0A5);
    frame(1'b1, 9'h13C, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(buf_wr && buf_addr, "R1 address type", {buf_wr, buf_addr}, 3);
    chk(buf_fe && buf_pe && buf_ovr, "R6 flags captured", {buf_fe, buf_pe, buf_ovr}, 7);
  endtask

  task automatic t_listen;
    csr_write(2'b01);
    chk(mode_q == 1'b1, "R8 mode set", mode_q, 1);
    frame(1'b1, 9'h042, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(buf_wr == 1'b0, "R2 data dropped", buf_wr, 0);
    chk(buf_fe == 1'b1 && buf_data == 9'h13C, "R7 state untouched", buf_data, 9'h13C);
    frame(1'b1, 9'h1F0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(buf_wr == 1'b1, "R3 address passes", buf_wr, 1);
    chk(buf_data == 9'h1F0, "R3 address data", buf_data, 9'h1F0);
    chk(!buf_fe && !buf_pe && !buf_ovr, "R7 no leaked flags",
        {buf_fe, buf_pe, buf_ovr}, 0);
  endtask

  task automatic t_narrow;
    frame(1'b0, 9'h17E, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(buf_wr == 1'b0, "R5 narrow data dropped", buf_wr, 0);
    frame(1'b0, 9'h17E, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(buf_wr && buf_addr, "R5 narrow address", {buf_wr, buf_addr}, 3);
    chk(buf_data == 9'h07E, "R5 top bit zero", buf_data, 9'h07E);
    chk(buf_fe == 1'b1, "R5 fe from second stop", buf_fe, 1);
  endtask

  task automatic t_collide;
    // mode currently 1: write 0 and finish a data frame in the same cycle
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 2'b00;
    nine_bit = 1'b1; rx_data = 9'h055; rx_stop1 = 1'b1; rx_done = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; rx_done = 1'b0;
    chk(buf_wr == 1'b0, "R11 old mode filters", buf_wr, 0);
    chk(mode_q == 1'b0, "R11 mode updated", mode_q, 0);
    frame(1'b1, 9'h066, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(buf_wr == 1'b1 && buf_data == 9'h066, "R4 data after clear", buf_data, 9'h066);
  endtask

  task automatic t_txc;
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    chk(txc_q == 1'b1, "R9 set", txc_q, 1);
    csr_write(2'b01);
    chk(txc_q == 1'b1, "R8 mode write keeps txc", txc_q, 1);
    chk(mode_q == 1'b1, "R8 mode", mode_q, 1);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 2'b11; tx_done = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; tx_done = 1'b0;
    chk(txc_q == 1'b1, "R9 set wins", txc_q, 1);
    csr_write(2'b10);
    chk(txc_q == 1'b0, "R9 clear by one", txc_q, 0);
    chk(mode_q == 1'b0, "R8 mode cleared", mode_q, 0);
  endtask

  initial begin
    rst_n = 1'b0; nine_bit = 1'b1; rx_data = '0; rx_stop1 = 1'b1; rx_stop2 = 1'b1;
    rx_par_err = 1'b0; rx_buf_full = 1'b0; rx_done = 1'b0;
    csr_wr = 1'b0; csr_wdata = '0; tx_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nine_open();
    t_listen();
    t_narrow();
    t_collide();
    t_txc();
    repeat (2) @(negedge clk);
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule